// File: doc/BRIEF.md
# Serial Register Write Port with Full-Duplex Result Readout

This block is a serial slave that takes register writes from a host over four wires: an active-low chip select, a serial clock, a data-in line and a data-out line. A fast system clock oversamples all the serial lines through synchronizers. The block samples data-in on each rising edge of the serial clock, most significant bit first. A frame of either 16 or 8 bits becomes a parallel register word at the moment chip select returns high. A frame of any other length is thrown away and an error pulse is raised.

An auxiliary converter is modelled as a ready flag and a 10-bit result word. The converter offers a result with a one-cycle valid pulse. Bit 0 of the last committed word acts as the read-enable. If read-enable is set and a result is waiting when a frame opens, the block drives the result out MSB first while the host writes its next frame. The ready flag is cleared once all ten bits have gone out. Otherwise the data-out driver stays released, and `miso_oe` is the pad's output-enable. The block also measures how long chip select stays high between frames, in system clocks, and flags a gap that is too short.

Top module: `spi_wr_port`

## Requirements
- R1: After reset, `reg_word` is 0, and `reg_wr`, `reg_short`, `frame_err`, `gap_err` and `miso_oe` are all 0.
- R2: While chip select is low, each rising edge of the serial clock shifts in one data-in bit, MSB first. A frame of exactly 16 bits sets `reg_word` to those bits, pulses `reg_wr` high for one system clock and clears `reg_short`.
- R3: Nothing is committed while chip select is low, even after 16 bits have arrived. `reg_word` and `reg_wr` change only after chip select rises.
- R4: A frame of exactly 8 bits sets `reg_word` to those 8 bits zero-extended, sets `reg_short` to 1 and pulses `reg_wr` once.
- R5: A frame of any other bit count, for example 12 or 17, leaves `reg_word` unchanged, gives no `reg_wr` pulse and pulses `frame_err` for one clock.
- R6: If chip select was high for fewer than MIN_GAP_CLKS system clocks (default 20, which is 80 ns at 250 MHz) before it falls, `gap_err` pulses once. A longer high time raises no error.
- R7: Between frames the serial clock may idle high or low, and frames decode the same way in both cases.
- R8: Read-enable is bit 0 of the last committed word. `miso_oe` rises in a frame only if read-enable is 1 and a result is ready when chip select falls. In every other case `miso_oe` stays 0 for the whole frame, and a result that was not sent stays ready.
- R9: When driving, `miso` shows bit 9 of the result from the opening of the frame. After the k-th serial clock rising edge it shows bit 9-k.
- R10: After the tenth rising edge of a driven frame, `miso_oe` drops and the ready flag clears. The next frame does not drive until the converter gives a new valid pulse.
- R11: Serial clock edges while chip select is high shift nothing into the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| mosi | input | 1 | Serial data in |
| aux_valid | input | 1 | One-cycle pulse: a new converter result is available |
| aux_data | input | 10 | Converter result, captured on `aux_valid` |
| miso | output | 1 | Serial data out (0 when not driving) |
| miso_oe | output | 1 | Output-enable for the data-out pad; 0 means high impedance |
| reg_word | output | 16 | Last committed register word |
| reg_wr | output | 1 | One-cycle pulse when `reg_word` is updated |
| reg_short | output | 1 | 1 when the last committed frame was 8 bits long |
| frame_err | output | 1 | One-cycle pulse for a frame with an illegal bit count |
| gap_err | output | 1 | One-cycle pulse when chip select falls after too short a high time |

## Verification
The hardest situation to reach is the readout, because it depends on state set up over several frames. Read-enable must already have been committed by an earlier frame. A converter result must be ready before the frame opens. The bench also has to read data-out just before every rising edge, while it is itself clocking a new write.

The stimulus first writes a word with bit 0 set and then pulses the converter. It then runs a full frame and records `miso` and `miso_oe` before each rising edge. A following frame shows that the ready flag has cleared. Separately, a result is pulsed while read-enable is 0, to show that the result is held back and sent only in the frame after read-enable returns.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

  typedef enum logic [1:0] {
    FR_NONE  = 2'd0,
    FR_FULL  = 2'd1,
    FR_SHORT = 2'd2,
    FR_BAD   = 2'd3
  } frame_kind_e;

  // Decide what a frame of a given bit count commits.
  function automatic frame_kind_e classify(input int unsigned bits,
                                           input int unsigned full_w,
                                           input int unsigned short_w);
    if (bits == full_w)       return FR_FULL;
    else if (bits == short_w) return FR_SHORT;
    else                      return FR_BAD;
  endfunction

  // True when the chip-select high time is below the minimum.
  function automatic logic gap_too_short(input int unsigned high_clks,
                                         input int unsigned min_clks);
    return high_clks < min_clks;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_wr_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int SHORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall_ev,
  input  logic              cs_rise_ev,
  input  logic              bit_ev,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_q,
  output logic              wr_pulse,
  output logic              short_q,
  output logic              err_pulse,
  output logic              rd_en
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  frame_kind_e       kind;

  always_comb kind = classify(32'(cnt), WORD_W, SHORT_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      cnt       <= '0;
      word_q    <= '0;
      wr_pulse  <= 1'b0;
      short_q   <= 1'b0;
      err_pulse <= 1'b0;
      rd_en     <= 1'b0;
    end else begin
      wr_pulse  <= 1'b0;
      err_pulse <= 1'b0;
      if (cs_fall_ev) begin
        cnt <= '0;
      end else if (bit_ev) begin
        sh <= {sh[WORD_W-2:0], bit_in};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
      if (cs_rise_ev) begin
        case (kind)
          FR_FULL: begin
            word_q   <= sh;
            wr_pulse <= 1'b1;
            short_q  <= 1'b0;
            rd_en    <= sh[0];
          end
          FR_SHORT: begin
            word_q   <= WORD_W'(sh[SHORT_W-1:0]);
            wr_pulse <= 1'b1;
            short_q  <= 1'b1;
            rd_en    <= sh[0];
          end
          default: err_pulse <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_aux_tx.sv
module spi_aux_tx #(
  parameter int AUX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aux_valid,
  input  logic [AUX_W-1:0] aux_data,
  input  logic             rd_en,
  input  logic             cs_fall_ev,
  input  logic             cs_rise_ev,
  input  logic             bit_ev,
  output logic             miso,
  output logic             miso_oe,
  output logic             done_ev
);
  localparam int BC_W = $clog2(AUX_W + 1);

  logic [AUX_W-1:0] aux_q;
  logic [AUX_W-1:0] txsh;
  logic [BC_W-1:0]  bc;
  logic             ready_q;
  logic             oe_q;
  logic             start_ev;

  assign start_ev = cs_fall_ev && rd_en && ready_q;
  assign done_ev  = oe_q && bit_ev && !cs_fall_ev && !cs_rise_ev
                    && (bc == BC_W'(AUX_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsh <= '0;
      bc   <= '0;
      oe_q <= 1'b0;
    end else if (start_ev) begin
      txsh <= aux_q;
      bc   <= '0;
      oe_q <= 1'b1;
    end else if (cs_rise_ev) begin
      oe_q <= 1'b0;
    end else if (oe_q && bit_ev) begin
      txsh <= {txsh[AUX_W-2:0], 1'b0};
      bc   <= bc + 1'b1;
      if (done_ev) oe_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q   <= '0;
      ready_q <= 1'b0;
    end else if (aux_valid) begin
      aux_q   <= aux_data;
      ready_q <= 1'b1;
    end else if (done_ev) begin
      ready_q <= 1'b0;
    end
  end

  assign miso_oe = oe_q;
  assign miso    = oe_q ? txsh[AUX_W-1] : 1'b0;
endmodule

// File: rtl/spi_cs_gap.sv
module spi_cs_gap
  import spi_wr_pkg::*;
#(
  parameter int MIN_GAP = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_high_s,
  input  logic cs_rise_ev,
  input  logic cs_fall_ev,
  output logic gap_err
);
  localparam int CG_W = $clog2(MIN_GAP + 1);

  logic [CG_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CG_W'(MIN_GAP);
      gap_err <= 1'b0;
    end else begin
      gap_err <= cs_fall_ev && gap_too_short(32'(cnt), MIN_GAP);
      if (cs_rise_ev) cnt <= CG_W'(1);
      else if (cs_high_s && cnt != CG_W'(MIN_GAP)) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_wr_port.sv
module spi_wr_port #(
  parameter int WORD_W       = 16,
  parameter int SHORT_W      = 8,
  parameter int AUX_W        = 10,
  parameter int MIN_GAP_CLKS = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              aux_valid,
  input  logic [AUX_W-1:0]  aux_data,
  output logic              miso,
  output logic              miso_oe,
  output logic [WORD_W-1:0] reg_word,
  output logic              reg_wr,
  output logic              reg_short,
  output logic              frame_err,
  output logic              gap_err
);
  logic [2:0] sync_q;
  logic       cs_n_s, sclk_s, mosi_s;
  logic       cs_n_p, sclk_p;
  logic       cs_low_s, cs_fall_ev, cs_rise_ev, bit_ev;
  logic       rd_en;
  logic       aux_done;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({mosi, sclk, cs_n}), .dout(sync_q)
  );

  assign cs_n_s = sync_q[0];
  assign sclk_s = sync_q[1];
  assign mosi_s = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_p <= 1'b1;
      sclk_p <= 1'b0;
    end else begin
      cs_n_p <= cs_n_s;
      sclk_p <= sclk_s;
    end
  end

  assign cs_low_s   = !cs_n_s;
  assign cs_fall_ev = cs_n_p && !cs_n_s;
  assign cs_rise_ev = !cs_n_p && cs_n_s;
  assign bit_ev     = cs_low_s && sclk_s && !sclk_p;

  spi_rx_frame #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev),
    .bit_ev(bit_ev), .bit_in(mosi_s),
    .word_q(reg_word), .wr_pulse(reg_wr), .short_q(reg_short),
    .err_pulse(frame_err), .rd_en(rd_en)
  );

  spi_aux_tx #(.AUX_W(AUX_W)) u_aux (
    .clk(clk), .rst_n(rst_n),
    .aux_valid(aux_valid), .aux_data(aux_data), .rd_en(rd_en),
    .cs_fall_ev(cs_fall_ev), .cs_rise_ev(cs_rise_ev), .bit_ev(bit_ev),
    .miso(miso), .miso_oe(miso_oe), .done_ev(aux_done)
  );

  spi_cs_gap #(.MIN_GAP(MIN_GAP_CLKS)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .cs_high_s(cs_n_s), .cs_rise_ev(cs_rise_ev), .cs_fall_ev(cs_fall_ev),
    .gap_err(gap_err)
  );
endmodule

// File: rtl/spi_wr_port_chk.sv
module spi_wr_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_low_s,
  input logic              cs_fall_ev,
  input logic              bit_ev,
  input logic              aux_done,
  input logic              miso,
  input logic              miso_oe,
  input logic [WORD_W-1:0] reg_word,
  input logic              reg_wr,
  input logic              frame_err,
  input logic              gap_err
);
  // R5
  commit_xor_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && frame_err));

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R3
  word_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_word) |-> reg_wr);

  // R8
  oe_inside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> $past(cs_low_s));

  // R9
  miso_holds_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$past(bit_ev)) |-> $stable(miso));

  // R6
  gap_err_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> $past(cs_fall_ev));

  // R10
  release_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_done |=> !miso_oe);
endmodule

bind spi_wr_port spi_wr_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_low_s(cs_low_s), .cs_fall_ev(cs_fall_ev),
  .bit_ev(bit_ev), .aux_done(aux_done), .miso(miso), .miso_oe(miso_oe),
  .reg_word(reg_word), .reg_wr(reg_wr), .frame_err(frame_err), .gap_err(gap_err)
);

// File: tb/spi_wr_port_tb.sv
module spi_wr_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic        aux_valid = 1'b0;
  logic [9:0]  aux_data = '0;
  logic        miso, miso_oe, reg_wr, reg_short, frame_err, gap_err;
  logic [15:0] reg_word;

  int total = 0, fails = 0;
  int wr_cnt = 0, ferr_cnt = 0, gerr_cnt = 0;
  logic        oe_seen = 1'b0;
  logic [15:0] rd_bits = '0, oe_bits = '0;
  bit          done = 0;

  always #2 clk = ~clk;

  spi_wr_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .aux_valid(aux_valid), .aux_data(aux_data), .miso(miso), .miso_oe(miso_oe),
    .reg_word(reg_word), .reg_wr(reg_wr), .reg_short(reg_short),
    .frame_err(frame_err), .gap_err(gap_err)
  );

  always @(posedge clk) begin
    if (reg_wr) wr_cnt++;
    if (frame_err) ferr_cnt++;
    if (gap_err) gerr_cnt++;
    if (miso_oe) oe_seen <= 1'b1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start_frame(input logic idle_hi);
    @(negedge clk);
    sclk = idle_hi;
    oe_seen = 1'b0;
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b0;
    mosi = b;
    repeat (8) @(negedge clk);
    rd_bits = {rd_bits[14:0], miso};
    oe_bits = {oe_bits[14:0], miso_oe};
    sclk = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic end_frame(input logic idle_hi, input int gap);
    sclk = idle_hi;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [31:0] data,
                       input logic idle_hi, input int gap);
    start_frame(idle_hi);
    for (int i = nbits - 1; i >= 0; i--) send_bit(data[i]);
    end_frame(idle_hi, gap);
  endtask

  task automatic pulse_aux(input logic [9:0] d);
    @(negedge clk);
    aux_valid = 1'b1;
    aux_data = d;
    @(negedge clk);
    aux_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reg_word", 32'(reg_word), 0);
    check("R1 outputs", {27'd0, reg_wr, reg_short, frame_err, gap_err, miso_oe}, 0);
  endtask

  task automatic t_full;
    int w0 = wr_cnt;
    frame(16, 32'hA5C3, 1'b0, 30);
    check("R2 word", 32'(reg_word), 32'hA5C3);
    check("R2 pulses", 32'(wr_cnt - w0), 1);
    check("R2 short flag", 32'(reg_short), 0);
    check("R8 no result no drive", 32'(oe_seen), 0);
  endtask

  task automatic t_hold;
    int w0 = wr_cnt;
    start_frame(1'b0);
    for (int i = 15; i >= 0; i--) send_bit(1'(16'h3E7B >> i));
    repeat (20) @(negedge clk);
    check("R3 word held while cs low", 32'(reg_word), 32'hA5C3);
    check("R3 no pulse while cs low", 32'(wr_cnt - w0), 0);
    end_frame(1'b0, 30);
    check("R3 word after cs rise", 32'(reg_word), 32'h3E7B);
  endtask

  task automatic t_short;
    int w0 = wr_cnt;
    frame(8, 32'h3C, 1'b0, 30);
    check("R4 word", 32'(reg_word), 32'h003C);
    check("R4 short flag", 32'(reg_short), 1);
    check("R4 pulses", 32'(wr_cnt - w0), 1);
  endtask

  task automatic t_bad;
    int w0 = wr_cnt;
    int e0 = ferr_cnt;
    frame(12, 32'hFFF, 1'b0, 30);
    check("R5 12-bit word kept", 32'(reg_word), 32'h003C);
    check("R5 12-bit error", 32'(ferr_cnt - e0), 1);
    frame(17, 32'h1FFFF, 1'b0, 30);
    check("R5 17-bit word kept", 32'(reg_word), 32'h003C);
    check("R5 errors and no pulse", 32'((ferr_cnt - e0) * 16 + (wr_cnt - w0)), 32'h20);
  endtask

  task automatic t_idle_hi;
    frame(16, 32'h5A0E, 1'b1, 30);
    check("R7 idle-high word", 32'(reg_word), 32'h5A0E);
    frame(8, 32'h81, 1'b1, 30);
    check("R7 idle-high short word", 32'(reg_word), 32'h0081);
  endtask

  task automatic t_cs_high_clocks;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1;
      sclk = 1'b1; repeat (6) @(negedge clk);
      sclk = 1'b0; repeat (6) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    frame(16, 32'h0F00, 1'b0, 30);
    check("R11 clocks with cs high ignored", 32'(reg_word), 32'h0F00);
  endtask

  task automatic t_gap;
    int g0 = gerr_cnt;
    frame(16, 32'h1110, 1'b0, 4);
    frame(16, 32'h2220, 1'b0, 40);
    check("R6 short gap flagged", 32'(gerr_cnt - g0), 1);
    frame(16, 32'h3330, 1'b0, 30);
    check("R6 long gap clean", 32'(gerr_cnt - g0), 1);
  endtask

  task automatic t_read;
    frame(16, 32'h0001, 1'b0, 30);
    pulse_aux(10'h2A5);
    repeat (30) @(negedge clk);
    frame(16, 32'h1235, 1'b0, 30);
    check("R9 result bits", 32'(rd_bits[15:6]), 32'h2A5);
    check("R10 oe over frame", 32'(oe_bits), 32'hFFC0);
    frame(16, 32'h0001, 1'b0, 30);
    check("R10 ready cleared", 32'(oe_seen), 0);
  endtask

  task automatic t_rd_en_off;
    frame(16, 32'h0000, 1'b0, 30);
    pulse_aux(10'h155);
    repeat (30) @(negedge clk);
    frame(16, 32'h0001, 1'b0, 30);
    check("R8 read-enable off no drive", 32'(oe_seen), 0);
    frame(16, 32'h0000, 1'b0, 30);
    check("R8 held result now sent", 32'(oe_seen), 1);
    check("R9 held result bits", 32'(rd_bits[15:6]), 32'h155);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full();
    t_hold();
    t_short();
    t_bad();
    t_idle_hi();
    t_cs_high_clocks();
    t_gap();
    t_read();
    t_rd_en_off();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule